// File: doc/BRIEF.md
# Single-Level Page Table Lookup Unit

This unit translates a 32-bit virtual address into a 30-bit physical address using a flat page table held in on-chip storage. The page is 4 KB. The upper 20 address bits form the virtual page number, and the low 12 bits are the offset within the page. The table slot is chosen by adding a base register to the low part of the page number. The slot supplies an 18-bit physical frame number. That frame number is joined to the untouched offset to form the physical address. The lookup fails with a fault in three cases: the slot is not present, the page number lies beyond the table, or a write hits a page that is marked read-only.

A supervisor write port loads table slots and the base register. A read port shows any slot's fields and its two status flags. Each successful access sets the slot's "touched" flag, and each successful write also sets its "modified" flag. A single-cycle command clears every touched flag at once, so software can sample recent use and approximate least-recently-used replacement. It also knows which frames need writing back.

Top module: `pt_walk`

## Requirements
- R1: A request sampled on a rising edge is answered with a one-cycle `done` pulse two rising edges later; `done` never rises without such a request.
- R2: On success `pa` equals the slot's frame number in bits 29..12 followed by the request's offset `va[11:0]` in bits 11..0, and `fault` is 0.
- R3: The slot index is (base + `va[19:12]`) modulo 256; the base is loaded from `base_in` when `base_ld` is high and is 0 after reset.
- R4: A lookup whose slot has its present bit at 0 returns `fault`=1 with `pa`=0.
- R5: A lookup whose `va[31:20]` is non-zero returns `fault`=1 with `pa`=0.
- R6: A write request (`wr`=1) to a slot whose write-permission bit is 0 returns `fault`=1 with `pa`=0.
- R7: A successful lookup sets the slot's touched flag; a faulting lookup changes no flag.
- R8: A successful write sets the slot's modified flag; a read leaves it unchanged.
- R9: `clr_touch` clears the touched flag of every slot and leaves all modified flags as they are.
- R10: When `clr_touch` is high on the same edge that completes a successful lookup, that lookup's slot ends with its touched flag set.
- R11: A table-port write loads present, write-permission and frame number into the slot and clears both of its status flags.
- R12: After reset every slot is absent with both flags clear, and `done` and `fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Lookup request strobe |
| va | input | 32 | Virtual address |
| wr | input | 1 | 1 = write access, 0 = read access |
| done | output | 1 | Lookup result valid (one cycle) |
| fault | output | 1 | Page fault, valid with done |
| pa | output | 30 | Physical address, valid with done |
| base_ld | input | 1 | Load the table base register |
| base_in | input | 8 | New table base |
| clr_touch | input | 1 | Clear all touched flags |
| tw_en | input | 1 | Table slot write enable |
| tw_idx | input | 8 | Slot being written |
| tw_present | input | 1 | Present bit to store |
| tw_wok | input | 1 | Write-permission bit to store |
| tw_frame | input | 18 | Frame number to store |
| rd_idx | input | 8 | Slot to inspect |
| rd_present | output | 1 | Inspected slot present bit |
| rd_wok | output | 1 | Inspected slot write permission |
| rd_touch | output | 1 | Inspected slot touched flag |
| rd_mod | output | 1 | Inspected slot modified flag |
| rd_frame | output | 18 | Inspected slot frame number |

## Verification
Two things can land on the same edge: the flag update at the end of a successful lookup, and the bulk clear of touched flags. The bench sets up this clash on purpose. It first marks several slots as touched. It then asserts `clr_touch` in exactly the cycle in which a lookup completes. Afterwards it reads slots back through the inspection port. The pass condition is that only the slot just accessed still shows touched, while every modified flag is unchanged.

// File: rtl/pt_walk.sv
module pt_walk #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PPN_W = 18,
  parameter int IDX_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic [VA_W-1:0]          va,
  input  logic                     wr,
  output logic                     done,
  output logic                     fault,
  output logic [PPN_W+OFF_W-1:0]   pa,
  input  logic                     base_ld,
  input  logic [IDX_W-1:0]         base_in,
  input  logic                     clr_touch,
  input  logic                     tw_en,
  input  logic [IDX_W-1:0]         tw_idx,
  input  logic                     tw_present,
  input  logic                     tw_wok,
  input  logic [PPN_W-1:0]         tw_frame,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic                     rd_present,
  output logic                     rd_wok,
  output logic                     rd_touch,
  output logic                     rd_mod,
  output logic [PPN_W-1:0]         rd_frame
);
  localparam int N    = 1 << IDX_W;
  localparam int PA_W = PPN_W + OFF_W;

  logic [N-1:0]     present_q, wok_q, touch_q, mod_q;
  logic [PPN_W-1:0] frame_q [N];
  logic [IDX_W-1:0] base_q;

  logic             s1_v, s1_wr, s1_oor, s1_p, s1_w;
  logic [IDX_W-1:0] s1_idx;
  logic [OFF_W-1:0] s1_off;
  logic [PPN_W-1:0] s1_frame;

  wire [IDX_W-1:0] idx  = base_q + va[OFF_W+IDX_W-1:OFF_W];
  wire             oor  = |va[VA_W-1:OFF_W+IDX_W];
  wire             flt  = s1_oor | ~s1_p | (s1_wr & ~s1_w);
  wire             hit  = s1_v & ~flt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      base_q <= '0;
    end else begin
      s1_v <= req;
      if (base_ld) base_q <= base_in;
    end
    if (req) begin
      s1_wr    <= wr;
      s1_oor   <= oor;
      s1_idx   <= idx;
      s1_off   <= va[OFF_W-1:0];
      s1_p     <= present_q[idx];
      s1_w     <= wok_q[idx];
      s1_frame <= frame_q[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done  <= 1'b0;
      fault <= 1'b0;
      pa    <= '0;
    end else begin
      done  <= s1_v;
      fault <= s1_v & flt;
      pa    <= hit ? {s1_frame, s1_off} : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      present_q <= '0;
      wok_q     <= '0;
      touch_q   <= '0;
      mod_q     <= '0;
    end else begin
      if (clr_touch) touch_q <= '0;
      if (hit) begin
        touch_q[s1_idx] <= 1'b1;
        if (s1_wr) mod_q[s1_idx] <= 1'b1;
      end
      if (tw_en) begin
        present_q[tw_idx] <= tw_present;
        wok_q[tw_idx]     <= tw_wok;
        touch_q[tw_idx]   <= 1'b0;
        mod_q[tw_idx]     <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk)
    if (tw_en) frame_q[tw_idx] <= tw_frame;

  assign rd_present = present_q[rd_idx];
  assign rd_wok     = wok_q[rd_idx];
  assign rd_touch   = touch_q[rd_idx];
  assign rd_mod     = mod_q[rd_idx];
  assign rd_frame   = frame_q[rd_idx];

  logic unused_pa_w;
  assign unused_pa_w = ^PA_W;
endmodule

// File: rtl/pt_walk_chk.sv
module pt_walk_chk #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PA_W  = 30
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req,
  input logic [VA_W-1:0] va,
  input logic            done,
  input logic            fault,
  input logic [PA_W-1:0] pa
);
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) req |-> ##2 done); // R1
  AST_DONE_CAUSED: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(req, 2)); // R1
  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) fault |-> done); // R4
  AST_FAULT_PA_ZERO: assert property (@(posedge clk) disable iff (!rst_n) fault |-> pa == '0); // R5
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> pa[OFF_W-1:0] == $past(va[OFF_W-1:0], 2)); // R2
endmodule

bind pt_walk pt_walk_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PPN_W+OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .va(va), .done(done), .fault(fault), .pa(pa));

// File: tb/pt_walk_tb.sv
module pt_walk_tb;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic req = 0, wr = 0, done, fault;
  logic [31:0] va = 0;
  logic [29:0] pa;
  logic base_ld = 0, clr_touch = 0, tw_en = 0, tw_present = 0, tw_wok = 0;
  logic [7:0] base_in = 0, tw_idx = 0, rd_idx = 0;
  logic [17:0] tw_frame = 0, rd_frame;
  logic rd_present, rd_wok, rd_touch, rd_mod;

  int total = 0, bad = 0;
  bit m_p[256], m_w[256], m_t[256], m_m[256];
  logic [17:0] m_f[256];
  logic [7:0] m_base = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walk u_dut (.*);

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic bit exp_fault(input logic [31:0] a, input bit w);
    logic [7:0] i = m_base + a[19:12];
    return (a[31:20] != 0) || !m_p[i] || (w && !m_w[i]);
  endfunction

  function automatic logic [29:0] exp_pa(input logic [31:0] a);
    logic [7:0] i = m_base + a[19:12];
    return {m_f[i], a[11:0]};
  endfunction

  task automatic twrite(input logic [7:0] i, input bit p, input bit w, input logic [17:0] f);
    @(negedge clk); tw_en = 1; tw_idx = i; tw_present = p; tw_wok = w; tw_frame = f;
    @(negedge clk); tw_en = 0;
    m_p[i] = p; m_w[i] = w; m_f[i] = f; m_t[i] = 0; m_m[i] = 0;
  endtask

  task automatic setbase(input logic [7:0] b);
    @(negedge clk); base_ld = 1; base_in = b;
    @(negedge clk); base_ld = 0; m_base = b;
  endtask

  task automatic clear_touch();
    @(negedge clk); clr_touch = 1;
    @(negedge clk); clr_touch = 0;
    foreach (m_t[i]) m_t[i] = 0;
  endtask

  task automatic lookup(input logic [31:0] a, input bit w, input bit clr_mid, input string rq);
    bit ef = exp_fault(a, w);
    logic [29:0] ep = ef ? 30'd0 : exp_pa(a);
    logic [7:0] i = m_base + a[19:12];
    @(negedge clk); req = 1; va = a; wr = w;
    @(negedge clk); req = 0; if (clr_mid) clr_touch = 1;
    @(negedge clk); clr_touch = 0;
    if (clr_mid) foreach (m_t[k]) m_t[k] = 0;
    if (!ef && a[31:20] == 0) begin m_t[i] = 1; if (w) m_m[i] = 1; end
    chk({rq, " R1 done"}, done, 1);
    chk({rq, " fault"}, fault, ef);
    chk({rq, " R2 pa"}, pa, ep);
    rd_idx = i; #1;
    chk({rq, " R7 touched"}, rd_touch, m_t[i]);
    chk({rq, " R8 modified"}, rd_mod, m_m[i]);
    @(negedge clk);
    chk({rq, " R1 single pulse"}, done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    foreach (m_p[i]) begin m_p[i] = 0; m_w[i] = 0; m_t[i] = 0; m_m[i] = 0; m_f[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 done", done, 0);
    chk("R12 fault", fault, 0);
    for (int i = 0; i < 256; i += 51) begin
      rd_idx = i[7:0]; #1;
      chk("R12 absent", {rd_present, rd_touch, rd_mod}, 0);
    end
    twrite(8'd5, 1, 1, 18'h2abcd);
    rd_idx = 5; #1;
    chk("R11 fields", {rd_present, rd_wok, rd_frame}, {2'b11, 18'h2abcd});
    lookup(32'h0000_5123, 0, 0, "R2 read");
    lookup(32'h0000_5fff, 1, 0, "R8 write");
    lookup(32'h0000_6000, 0, 0, "R4 absent");
    lookup(32'h0010_5000, 0, 0, "R5 out of range");
    twrite(8'd9, 1, 0, 18'h00777);
    lookup(32'h0000_9abc, 1, 0, "R6 read-only write");
    lookup(32'h0000_9abc, 0, 0, "R6 read-only read");
    setbase(8'd250);
    twrite(8'd1, 1, 1, 18'h3ffff);
    lookup(32'h0000_7001, 0, 0, "R3 base wrap");
    lookup(32'h0000_b002, 1, 0, "R3 base offset");
    setbase(8'd0);
    clear_touch();
    rd_idx = 5; #1;
    chk("R9 touched cleared", rd_touch, 0);
    chk("R9 modified kept", rd_mod, 1);
    lookup(32'h0000_9000, 0, 0, "R10 prep");
    lookup(32'h0000_5004, 0, 1, "R10 clash");
    rd_idx = 9; #1;
    chk("R10 other slot cleared", rd_touch, 0);
    twrite(8'd5, 1, 0, 18'h11111);
    rd_idx = 5; #1;
    chk("R11 flags cleared", {rd_touch, rd_mod}, 0);
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 9);
      logic [7:0] r = 8'($urandom);
      if (op < 3) twrite(r, $urandom_range(0, 3) != 0, 1'($urandom), 18'($urandom));
      else if (op == 3) clear_touch();
      else if (op == 4) setbase(8'($urandom_range(0, 3)));
      else begin
        logic [31:0] a = $urandom;
        if ($urandom_range(0, 7) != 0) a[31:20] = 0;
        lookup(a, 1'($urandom), $urandom_range(0, 9) == 0, "R2 random");
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule